// File: doc/BRIEF.md
# Compact Multicycle 16-Round Feistel Cipher Core (SEED structure)

This core encrypts or decrypts one 128-bit block under a 128-bit key. It follows the SEED structure: sixteen Feistel rounds over two 64-bit halves, with a round function built from a 32-bit G mixing function and 32-bit modular additions. The core is built for small area. The data side owns exactly one G unit, and each round is spread over three clock cycles so that unit is used once per cycle. The key side owns a second G unit, which produces the two 32-bit halves of the next round key on the fly in two of those three cycles. No key table is stored.

The caller presents the key, the block and the direction, then pulses `start_i` while the core is idle. Fifty-two cycles later the result appears on `data_o`, and `done_o` is high for one cycle. For decryption, the schedule register starts from the last round key's state and is stepped backward. The round keys therefore come out in reverse order, and no pre-computation pass is needed.

Top module: `seed_compact_core`

## Requirements
- R1: After reset, and until the first operation completes, `done_o` is 0 and `data_o` is all zeros.
- R2: Decrypting the ciphertext of block P under key K, using the same key K, returns P exactly.
- R3: Encryption works as follows. Split the block into L = bits 127:64 and R = bits 63:0. Each of the 16 rounds maps (L, R) to (R, L xor F(R, k)). The output is {R16, L16}. With C = R[63:32] xor k[63:32], D = R[31:0] xor k[31:0], t1 = G(C xor D), t2 = G(t1 + C) and t3 = G(t2 + t1), F returns {t2 + t3, t3}. All additions are modulo 2^32.
- R4: G works as follows. Input bytes X0 (bits 7:0) and X2 pass through S1, and bytes X1 and X3 pass through S2. Output byte Zj is the xor over b of (Yb & M[(b+j) mod 4]), with M = {FC, F3, CF, 3F}. S1(x) = a1(x^247) xor A9 and S2(x) = a2(x^251) xor 38, computed in GF(2^8) modulo x^8+x^6+x^5+x+1. Here a1(y) = y^rl1^rl2^rl3^rl4 and a2(y) = y^rl1^rl3^rl6, where rln is y rotated left by n bits.
- R5: The key schedule works as follows. Split the key into A, B, C, D, from the most significant word to the least. Round key i (1..16) is {G(A + C - KCi), G(B - D + KCi)}, with KC1 = 9E3779B9 and each following constant rotated left by 1 bit. After an odd round i, {A,B} rotates right by 8 bits. After an even round i, {C,D} rotates left by 8 bits.
- R6: Decryption applies the same round structure with the round keys in order 16 down to 1.
- R7: `done_o` rises at the 51st rising edge after the edge that samples `start_i` in idle. The operation therefore spans 52 cycles, counting the start cycle.
- R8: `done_o` is high for exactly one cycle per operation.
- R9: `data_o` changes only on the edge that raises `done_o`, and holds its value between operations.
- R10: While an operation is running, `start_i`, `decrypt_i`, `key_i` and `data_i` have no effect on the running result, and no extra operation is queued.
- R11: A `start_i` sampled in the cycle where `done_o` is high is accepted, and it runs with the full latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled only while idle) |
| decrypt_i | input | 1 | 1 selects decryption, 0 selects encryption |
| key_i | input | 128 | Cipher key |
| data_i | input | 128 | Input block |
| data_o | output | 128 | Result block, held until the next completion |
| done_o | output | 1 | One-cycle pulse when `data_o` is updated |

## Verification
The assertions watch the control behaviour on every cycle:
- `done_o` is a single-cycle pulse that arrives 52 cycles after acceptance.
- `data_o` is frozen outside completions.
- The setup state is entered only from idle.
- Completion always follows round 16, phase 2.

The values on the data path can only be shown by the bench scenarios. These compare ciphertexts and plaintexts against an independent forward-schedule reference model over a sweep of keys and blocks. They confirm that the backward schedule used for decryption matches the reversed forward keys. They also show that stimulus applied mid-operation leaves the result unchanged.

// File: rtl/seed_pkg.sv
package seed_pkg;

  localparam int          N_ROUNDS   = 16;
  localparam int          N_PHASES   = 3;
  localparam int          RND_W      = $clog2(N_ROUNDS + 1);
  localparam int          KIDX_W     = RND_W + 1;
  localparam logic [7:0]  FIELD_LOW  = 8'h63;
  localparam logic [7:0]  S1_CONST   = 8'hA9;
  localparam logic [7:0]  S2_CONST   = 8'h38;
  localparam logic [31:0] KC_FIRST   = 32'h9E3779B9;
  localparam logic [31:0] KC_LAST    = {KC_FIRST[16:0], KC_FIRST[31:17]};

  typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_ROUND, ST_OUT} state_e;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? FIELD_LOW : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] gf_sq(input logic [7:0] a);
    return gf_mul(a, a);
  endfunction

  // a^254, zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] e3, e7, e15, e31, e63, e127;
    e3   = gf_mul(gf_sq(a), a);
    e7   = gf_mul(gf_sq(e3), a);
    e15  = gf_mul(gf_sq(e7), a);
    e31  = gf_mul(gf_sq(e15), a);
    e63  = gf_mul(gf_sq(e31), a);
    e127 = gf_mul(gf_sq(e63), a);
    return gf_sq(e127);
  endfunction

  function automatic logic [7:0] rol8(input logic [7:0] y, input int n);
    logic [15:0] w;
    w = {y, y} << n;
    return w[15:8];
  endfunction

  // x^247 = inverse of x^8
  function automatic logic [7:0] sbox_a(input logic [7:0] x);
    logic [7:0] y;
    y = gf_inv(gf_sq(gf_sq(gf_sq(x))));
    return y ^ rol8(y, 1) ^ rol8(y, 2) ^ rol8(y, 3) ^ rol8(y, 4) ^ S1_CONST;
  endfunction

  // x^251 = inverse of x^4
  function automatic logic [7:0] sbox_b(input logic [7:0] x);
    logic [7:0] y;
    y = gf_inv(gf_sq(gf_sq(x)));
    return y ^ rol8(y, 1) ^ rol8(y, 3) ^ rol8(y, 6) ^ S2_CONST;
  endfunction

  function automatic logic [7:0] mix_mask(input int i);
    case (i % 4)
      0:       return 8'hFC;
      1:       return 8'hF3;
      2:       return 8'hCF;
      default: return 8'h3F;
    endcase
  endfunction

endpackage

// File: rtl/seed_gfunc.sv
module seed_gfunc
  import seed_pkg::*;
(
  input  logic [31:0] x_i,
  output logic [31:0] y_o
);

  logic [7:0] sb [4];

  for (genvar b = 0; b < 4; b++) begin : g_byte
    if (b % 2 == 0) begin : g_even
      assign sb[b] = sbox_a(x_i[8*b +: 8]);
    end else begin : g_odd
      assign sb[b] = sbox_b(x_i[8*b +: 8]);
    end
  end

  always_comb begin
    y_o = '0;
    for (int j = 0; j < 4; j++) begin
      for (int b = 0; b < 4; b++) begin
        y_o[8*j +: 8] = y_o[8*j +: 8] ^ (sb[b] & mix_mask(b + j));
      end
    end
  end

endmodule

// File: rtl/seed_keysched.sv
module seed_keysched
  import seed_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         decrypt_i,
  input  logic [127:0] key_i,
  input  logic         gen_hi_i,
  input  logic         gen_lo_i,
  output logic [63:0]  rkey_o
);

  logic [63:0]       ab_q, cd_q;
  logic [31:0]       kc_q;
  logic [KIDX_W-1:0] kidx_q;
  logic              dec_q;
  logic [31:0]       g_in, g_out;

  always_comb begin
    if (gen_lo_i) g_in = ab_q[31:0] - cd_q[31:0] + kc_q;
    else          g_in = ab_q[63:32] + cd_q[63:32] - kc_q;
  end

  seed_gfunc i_kgfunc (
    .x_i (g_in),
    .y_o (g_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ab_q   <= '0;
      cd_q   <= '0;
      kc_q   <= '0;
      kidx_q <= '0;
      dec_q  <= 1'b0;
      rkey_o <= '0;
    end else if (load_i) begin
      dec_q <= decrypt_i;
      ab_q  <= key_i[127:64];
      if (decrypt_i) begin
        // state of the last round key: {C,D} net rotation of right 8
        cd_q   <= {key_i[7:0], key_i[63:8]};
        kc_q   <= KC_LAST;
        kidx_q <= KIDX_W'(N_ROUNDS);
      end else begin
        cd_q   <= key_i[63:0];
        kc_q   <= KC_FIRST;
        kidx_q <= KIDX_W'(1);
      end
    end else if (gen_hi_i) begin
      rkey_o[63:32] <= g_out;
    end else if (gen_lo_i) begin
      rkey_o[31:0] <= g_out;
      if (!dec_q) begin
        if (kidx_q[0]) ab_q <= {ab_q[7:0], ab_q[63:8]};
        else           cd_q <= {cd_q[55:0], cd_q[63:56]};
        kc_q   <= {kc_q[30:0], kc_q[31]};
        kidx_q <= kidx_q + 1'b1;
      end else begin
        if (!kidx_q[0]) ab_q <= {ab_q[55:0], ab_q[63:56]};
        else            cd_q <= {cd_q[7:0], cd_q[63:8]};
        kc_q   <= {kc_q[0], kc_q[31:1]};
        kidx_q <= kidx_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/seed_round_dp.sv
module seed_round_dp
  import seed_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [1:0]   phase_i,
  input  logic [127:0] data_i,
  input  logic [63:0]  rkey_i,
  output logic [127:0] swap_o
);

  logic [63:0] l_q, r_q;
  logic [31:0] c_q, t1_q, t2_q;
  logic [31:0] c_mix, g_in, g_out;

  assign c_mix = r_q[63:32] ^ rkey_i[63:32];

  always_comb begin
    case (phase_i)
      2'd0:    g_in = c_mix ^ r_q[31:0] ^ rkey_i[31:0];
      2'd1:    g_in = t1_q + c_q;
      default: g_in = t2_q + t1_q;
    endcase
  end

  seed_gfunc i_dgfunc (
    .x_i (g_in),
    .y_o (g_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q  <= '0;
      r_q  <= '0;
      c_q  <= '0;
      t1_q <= '0;
      t2_q <= '0;
    end else if (load_i) begin
      l_q <= data_i[127:64];
      r_q <= data_i[63:0];
    end else if (step_i) begin
      case (phase_i)
        2'd0: begin
          c_q  <= c_mix;
          t1_q <= g_out;
        end
        2'd1: t2_q <= g_out;
        default: begin
          l_q <= r_q;
          r_q <= l_q ^ {t2_q + g_out, g_out};
        end
      endcase
    end
  end

  assign swap_o = {r_q, l_q};

endmodule

// File: rtl/seed_compact_core.sv
module seed_compact_core
  import seed_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         decrypt_i,
  input  logic [127:0] key_i,
  input  logic [127:0] data_i,
  output logic [127:0] data_o,
  output logic         done_o
);

  state_e           state_q;
  logic [RND_W-1:0] rnd_q;
  logic [1:0]       ph_q;
  logic             load, gen_hi, gen_lo, step, last_round;
  logic [63:0]      rkey;
  logic [127:0]     result;

  assign load       = (state_q == ST_IDLE) && start_i;
  assign last_round = (rnd_q == RND_W'(N_ROUNDS));
  // next-round key is built one round ahead; none after the last round
  assign gen_hi     = (ph_q == 2'd0) && ((state_q == ST_PREP) ||
                      ((state_q == ST_ROUND) && !last_round));
  assign gen_lo     = (ph_q == 2'd1) && ((state_q == ST_PREP) ||
                      ((state_q == ST_ROUND) && !last_round));
  assign step       = (state_q == ST_ROUND);

  seed_keysched i_keysched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .decrypt_i (decrypt_i),
    .key_i     (key_i),
    .gen_hi_i  (gen_hi),
    .gen_lo_i  (gen_lo),
    .rkey_o    (rkey)
  );

  seed_round_dp i_round_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .phase_i (ph_q),
    .data_i  (data_i),
    .rkey_i  (rkey),
    .swap_o  (result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rnd_q   <= '0;
      ph_q    <= '0;
      data_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_PREP;
          ph_q    <= '0;
          rnd_q   <= '0;
        end
        ST_PREP: begin
          if (ph_q == 2'd1) begin
            state_q <= ST_ROUND;
            ph_q    <= '0;
            rnd_q   <= RND_W'(1);
          end else begin
            ph_q <= ph_q + 2'd1;
          end
        end
        ST_ROUND: begin
          if (ph_q == 2'(N_PHASES - 1)) begin
            ph_q <= '0;
            if (last_round) state_q <= ST_OUT;
            else            rnd_q   <= rnd_q + 1'b1;
          end else begin
            ph_q <= ph_q + 2'd1;
          end
        end
        default: begin
          data_o  <= result;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/seed_compact_core_chk.sv
module seed_compact_core_chk
  import seed_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             done_o,
  input logic [127:0]     data_o,
  input state_e           state_q,
  input logic [RND_W-1:0] rnd_q,
  input logic [1:0]       ph_q
);

  localparam int LAT_W   = $clog2(N_ROUNDS * N_PHASES + 8) + 1;
  localparam int LAT_EXP = N_ROUNDS * N_PHASES + 4;

  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             lat_q <= '0;
    else if (state_q == ST_IDLE && start_i)  lat_q <= LAT_W'(1);
    else if (done_o)                         lat_q <= '0;
    else if (lat_q != '0)                    lat_q <= lat_q + 1'b1;
  end

  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == LAT_W'(LAT_EXP)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(data_o)); // R9

  AST_START_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PREP && ph_q == 2'd0) |-> $past(state_q) == ST_IDLE); // R10

  AST_PHASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q != 2'd3); // R3

  AST_ALL_ROUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OUT) |-> ($past(state_q) == ST_ROUND &&
                             $past(rnd_q) == RND_W'(N_ROUNDS) &&
                             $past(ph_q) == 2'd2)); // R3

endmodule

bind seed_compact_core seed_compact_core_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_o  (done_o),
  .data_o  (data_o),
  .state_q (state_q),
  .rnd_q   (rnd_q),
  .ph_q    (ph_q)
);

// File: tb/test_seed_compact_core.sv
`timescale 1ns/1ps
module test_seed_compact_core;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         decrypt_i = 1'b0;
  logic [127:0] key_i = '0;
  logic [127:0] data_i = '0;
  logic [127:0] data_o;
  logic         done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  seed_compact_core i_seed_compact_core (
    .clk_i, .rst_ni, .start_i, .decrypt_i, .key_i, .data_i, .data_o, .done_o
  );

  // ---------------- reference model (forward schedule only) ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = (x[7]) ? ((x << 1) ^ 8'h63) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] m_pow(input logic [7:0] x, input int e);
    logic [7:0] r = 8'h01;
    logic [7:0] s = x;
    for (int i = 0; i < 8; i++) begin
      if ((e >> i) & 1) r = m_mul(r, s);
      s = m_mul(s, s);
    end
    return r;
  endfunction

  function automatic logic [7:0] m_rl(input logic [7:0] y, input int n);
    return (y << n) | (y >> (8 - n));
  endfunction

  function automatic logic [31:0] m_g(input logic [31:0] x);
    logic [7:0] y [4];
    logic [7:0] m [4];
    logic [31:0] z = 0;
    logic [7:0] p;
    m[0] = 8'hFC; m[1] = 8'hF3; m[2] = 8'hCF; m[3] = 8'h3F;
    for (int b = 0; b < 4; b++) begin
      if (b % 2 == 0) begin
        p = m_pow(x[8*b +: 8], 247);
        y[b] = p ^ m_rl(p,1) ^ m_rl(p,2) ^ m_rl(p,3) ^ m_rl(p,4) ^ 8'hA9;
      end else begin
        p = m_pow(x[8*b +: 8], 251);
        y[b] = p ^ m_rl(p,1) ^ m_rl(p,3) ^ m_rl(p,6) ^ 8'h38;
      end
    end
    for (int j = 0; j < 4; j++)
      for (int b = 0; b < 4; b++)
        z[8*j +: 8] ^= y[b] & m[(b + j) % 4];
    return z;
  endfunction

  function automatic logic [127:0] m_cipher(input logic dec, input logic [127:0] key,
                                            input logic [127:0] blk);
    logic [63:0] ks [16];
    logic [63:0] ab = key[127:64];
    logic [63:0] cd = key[63:0];
    logic [31:0] kc = 32'h9E3779B9;
    logic [63:0] l = blk[127:64];
    logic [63:0] r = blk[63:0];
    logic [63:0] k, t;
    logic [31:0] c, t1, t2, t3;
    for (int i = 0; i < 16; i++) begin
      ks[i] = {m_g(ab[63:32] + cd[63:32] - kc), m_g(ab[31:0] - cd[31:0] + kc)};
      if (i % 2 == 0) ab = {ab[7:0], ab[63:8]};
      else            cd = {cd[55:0], cd[63:56]};
      kc = {kc[30:0], kc[31]};
    end
    for (int i = 0; i < 16; i++) begin
      k  = dec ? ks[15 - i] : ks[i];
      c  = r[63:32] ^ k[63:32];
      t1 = m_g(c ^ r[31:0] ^ k[31:0]);
      t2 = m_g(t1 + c);
      t3 = m_g(t2 + t1);
      t  = l ^ {t2 + t3, t3};
      l  = r;
      r  = t;
    end
    return {r, l};
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done_o && lat < 200) begin
      @(posedge clk_i); @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic run_op(input logic dec, input logic [127:0] k, input logic [127:0] d,
                        output logic [127:0] res, output int lat);
    @(negedge clk_i);
    start_i = 1'b1; decrypt_i = dec; key_i = k; data_i = d;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0; key_i = ~k; data_i = ~d; decrypt_i = ~dec;
    wait_done(lat);
    res = data_o;
    @(posedge clk_i); @(negedge clk_i);
    check(done_o == 1'b0, "R8 done pulse width", 128'(done_o), 128'd0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [127:0] key, pt, ct, bk, res, exp, held;
    int lat;
    repeat (3) @(negedge clk_i);
    check(done_o == 1'b0, "R1 done after reset", 128'(done_o), 128'd0);
    check(data_o == '0, "R1 data after reset", data_o, 128'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(data_o == '0 && !done_o, "R1 idle after release", data_o, 128'd0);

    // sweep of keys and blocks
    for (int v = 0; v < 10; v++) begin
      case (v)
        0: begin key = '0; pt = '0; end
        1: begin key = '1; pt = '1; end
        2: begin key = '0; pt = 128'h000102030405060708090A0B0C0D0E0F; end
        3: begin key = 128'h000102030405060708090A0B0C0D0E0F; pt = '0; end
        default: begin
          key = {32'(v) * 32'h9E3779B9, 32'(v) * 32'h85EBCA6B,
                 32'(v) * 32'hC2B2AE35, 32'(v) * 32'h27D4EB2F};
          pt  = {key[95:0], key[127:96]} ^ (128'd1 << (v * 13));
        end
      endcase
      exp = m_cipher(1'b0, key, pt);
      run_op(1'b0, key, pt, ct, lat);
      check(ct == exp, "R3,R4,R5 encrypt", ct, exp);
      check(lat == 51, "R7 encrypt latency", 128'(lat), 128'd51);
      exp = m_cipher(1'b1, key, ct);
      run_op(1'b1, key, ct, bk, lat);
      check(bk == exp, "R6 decrypt", bk, exp);
      check(bk == pt, "R2 round trip", bk, pt);
      check(lat == 51, "R7 decrypt latency", 128'(lat), 128'd51);
    end

    // R9: result held while idle with changing inputs
    held = data_o;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      key_i = key_i + 128'd7; data_i = data_i ^ 128'(i); decrypt_i = ~decrypt_i;
    end
    check(data_o == held, "R9 hold while idle", data_o, held);

    // R10: start during operation ignored
    key = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0; pt = 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D;
    exp = m_cipher(1'b0, key, pt);
    @(negedge clk_i);
    start_i = 1'b1; decrypt_i = 1'b0; key_i = key; data_i = pt;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    repeat (9) begin @(posedge clk_i); @(negedge clk_i); end
    check(data_o == held, "R9 hold while busy", data_o, held);
    start_i = 1'b1; decrypt_i = 1'b1; key_i = ~key; data_i = ~pt;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    lat = 10;
    begin
      int more;
      wait_done(more);
      lat = lat + more;
    end
    check(data_o == exp, "R10 busy start ignored result", data_o, exp);
    check(lat == 51, "R10 busy start latency", 128'(lat), 128'd51);
    begin
      int extra = 0;
      for (int i = 0; i < 70; i++) begin
        @(posedge clk_i); @(negedge clk_i);
        if (done_o) extra++;
      end
      check(extra == 0, "R10 no queued operation", 128'(extra), 128'd0);
    end

    // R11: start in the done cycle
    key = 128'h1111_2222_3333_4444_5555_6666_7777_8888; pt = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    run_op(1'b0, key, pt, ct, lat);
    @(negedge clk_i);
    start_i = 1'b1; decrypt_i = 1'b0; key_i = key; data_i = pt;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    wait_done(lat);
    // now in done cycle: issue decrypt
    start_i = 1'b1; decrypt_i = 1'b1; key_i = key; data_i = ct;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    wait_done(lat);
    check(data_o == pt, "R11 start in done cycle result", data_o, pt);
    check(lat == 51, "R11 start in done cycle latency", 128'(lat), 128'd51);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    finished = 1;
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule